// File: doc/BRIEF.md
# SDRAM Mode Register Command Issuer

This block sits between the register-write path of an SDRAM controller and its command sequencer. The controller serves two chip selects. Each chip select owns a mode register and a mobile extended mode register 2. A write names the chip select, which of the two registers it targets, a 12-bit value and a quiet flag. A mode register value is first checked for burst length, burst ordering and CAS latency. An illegal value is refused and flagged. A legal value, and any extended mode register 2 value, is stored.

Unless the quiet flag is set, the stored value also becomes a pending Load Mode Register request for that chip select. The request carries the bank-address code of the target register and uses the register value as the address word. A small state machine hands pending requests to the sequencer one at a time over a valid/acknowledge pair. It has two states. IDLE waits for work. SEND holds the command until it is acknowledged. The transition GRANT goes from IDLE to SEND when any chip select has a request pending, and it picks the lowest-numbered one. The transition RETIRE goes from SEND back to IDLE on an acknowledge, and it clears that chip select's request. Each chip select holds at most one request. A write to a chip select whose request is still pending is stalled.

Top module: `mrs_issuer`

## Requirements
- R1: After reset, `cmd_valid` is 0, `wr_ready` is 1, every mode register reads 0x032 and every extended mode register 2 reads 0x000.
- R2: A mode register value is legal only when all of these hold: bits [2:0] (burst length code) are 2 or 4, bit [3] (interleave) is 0, and bits [6:4] (CAS latency) are 1 to 5. An accepted write of an illegal value raises `wr_err` for exactly the cycle after the write edge, leaves the register unchanged and queues no command.
- R3: An accepted legal write stores all 12 bits into the register selected by `wr_cs` and `wr_ext`. `rd_data` shows the register selected by `rd_cs` and `rd_ext` (0 = mode register, 1 = extended mode register 2).
- R4: A legal mode register write without quiet issues a command with `cmd_ba` = 2'b00, `cmd_cs` equal to the chip select and `cmd_addr` equal to the written value.
- R5: An extended mode register 2 write is never refused. Without quiet it issues a command with `cmd_ba` = 2'b10 and `cmd_addr` equal to the written value.
- R6: A write with `wr_quiet` = 1 updates the register but issues no command.
- R7: Once `cmd_valid` is 1, it and `cmd_cs`, `cmd_ba` and `cmd_addr` stay unchanged until a cycle in which `cmd_ack` is 1.
- R8: `wr_ready` is 0 while the chip select named by `wr_cs` has a request pending. A write presented then is ignored and the register keeps its value.
- R9: After an acknowledged cycle, `cmd_valid` is 0 for one cycle. A request already pending for the other chip select is issued in the cycle after that.
- R10: With the state machine idle, a write accepted at clock edge k gives `cmd_valid` = 1 from edge k+1 on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_cs | input | 1 | Chip select targeted by the write |
| wr_ext | input | 1 | 0 = mode register, 1 = extended mode register 2 |
| wr_quiet | input | 1 | Store the value without issuing a command |
| wr_data | input | 12 | Register value |
| wr_ready | output | 1 | Low when the targeted chip select has a request pending |
| wr_err | output | 1 | One-cycle flag for a refused mode value |
| rd_cs | input | 1 | Chip select for readback |
| rd_ext | input | 1 | Register select for readback |
| rd_data | output | 12 | Readback value |
| cmd_valid | output | 1 | Load Mode Register command offered |
| cmd_ack | input | 1 | Sequencer takes the command |
| cmd_cs | output | 1 | Chip select of the command |
| cmd_ba | output | 2 | Bank-address code of the command |
| cmd_addr | output | 12 | Address word (register value) |

## Verification
Two things can happen in the same clock edge: a write is accepted for one chip select while the sequencer acknowledges the command held for the other. The bench provokes this by raising `cmd_ack` and `wr_en` together. It then expects the idle gap cycle and the new command right after it, with the new payload. In the opposite pairing, the write names the chip select being acknowledged. That write must be stalled, because the request is still pending at the edge, and the register must keep its old value. A reference model running alongside the design judges every output on every cycle.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

    localparam int REG_W = 12;

    typedef enum logic [1:0] {
        BA_MODE = 2'b00,
        BA_EXT2 = 2'b10
    } ba_code_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } fsm_state_e;

    typedef struct packed {
        logic [1:0]       ba;
        logic [REG_W-1:0] addr;
    } lmr_req_t;

endpackage

// File: rtl/mrs_field_check.sv
module mrs_field_check #(
    parameter int CL_MIN = 1,
    parameter int CL_MAX = 5,
    parameter int BL_SDR = 2,
    parameter int BL_DDR = 4
) (
    input  logic [6:0] value,
    input  logic       is_ext,
    output logic       ok
);
    logic [2:0] burst_code;
    logic [2:0] latency;
    logic       interleave;
    logic       burst_ok;
    logic       latency_ok;

    always_comb begin
        burst_code = value[2:0];
        interleave = value[3];
        latency    = value[6:4];
        burst_ok   = (burst_code == 3'(BL_SDR)) || (burst_code == 3'(BL_DDR));
        latency_ok = (int'(latency) >= CL_MIN) && (int'(latency) <= CL_MAX);
        ok         = is_ext || (burst_ok && !interleave && latency_ok);
    end
endmodule

// File: rtl/mrs_cs_slot.sv
module mrs_cs_slot
    import mrs_pkg::*;
#(
    parameter logic [REG_W-1:0] MR_RESET  = 12'h032,
    parameter logic [REG_W-1:0] EXT_RESET = 12'h000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic             wr_ok,
    input  logic             wr_ext,
    input  logic             wr_quiet,
    input  logic [REG_W-1:0] wr_data,
    input  logic             retire,
    output logic             pend,
    output lmr_req_t         req,
    output logic [REG_W-1:0] mr_q,
    output logic [REG_W-1:0] ext_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mr_q  <= MR_RESET;
            ext_q <= EXT_RESET;
            pend  <= 1'b0;
            req   <= '0;
        end else begin
            if (retire) begin
                pend <= 1'b0;
            end
            if (wr_hit && wr_ok) begin
                if (wr_ext) begin
                    ext_q <= wr_data;
                end else begin
                    mr_q <= wr_data;
                end
                if (!wr_quiet) begin
                    pend     <= 1'b1;
                    req.ba   <= wr_ext ? BA_EXT2 : BA_MODE;
                    req.addr <= wr_data;
                end
            end
        end
    end
endmodule

// File: rtl/mrs_cmd_fsm.sv
module mrs_cmd_fsm
    import mrs_pkg::*;
#(
    parameter int NUM_CS = 2,
    localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CS-1:0] pend,
    input  logic              cmd_ack,
    output logic              cmd_valid,
    output logic [CS_W-1:0]   cur_cs,
    output logic [NUM_CS-1:0] retire
);
    fsm_state_e      state, state_nxt;
    logic [CS_W-1:0] cur_nxt;
    logic [CS_W-1:0] first_pend;

    always_comb begin
        first_pend = '0;
        for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (pend[i]) begin
                first_pend = CS_W'(i);
            end
        end
    end

    always_comb begin
        state_nxt = state;
        cur_nxt   = cur_cs;
        unique case (state)
            ST_IDLE: begin
                if (|pend) begin
                    state_nxt = ST_SEND;
                    cur_nxt   = first_pend;
                end
            end
            ST_SEND: begin
                if (cmd_ack) begin
                    state_nxt = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cur_cs <= '0;
        end else begin
            state  <= state_nxt;
            cur_cs <= cur_nxt;
        end
    end

    always_comb begin
        cmd_valid = (state == ST_SEND);
        for (int i = 0; i < NUM_CS; i++) begin
            retire[i] = (state == ST_SEND) && cmd_ack && (cur_cs == CS_W'(i));
        end
    end
endmodule

// File: rtl/mrs_issuer.sv
module mrs_issuer
    import mrs_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter logic [REG_W-1:0] MR_RESET = 12'h032,
    localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CS_W-1:0]  wr_cs,
    input  logic             wr_ext,
    input  logic             wr_quiet,
    input  logic [REG_W-1:0] wr_data,
    output logic             wr_ready,
    output logic             wr_err,
    input  logic [CS_W-1:0]  rd_cs,
    input  logic             rd_ext,
    output logic [REG_W-1:0] rd_data,
    output logic             cmd_valid,
    input  logic             cmd_ack,
    output logic [CS_W-1:0]  cmd_cs,
    output logic [1:0]       cmd_ba,
    output logic [REG_W-1:0] cmd_addr
);
    logic [NUM_CS-1:0] pend;
    logic [NUM_CS-1:0] retire;
    logic [NUM_CS-1:0] hit;
    lmr_req_t          req_arr [NUM_CS];
    logic [REG_W-1:0]  mr_arr  [NUM_CS];
    logic [REG_W-1:0]  ext_arr [NUM_CS];
    logic              value_ok;
    logic              accept;
    logic [CS_W-1:0]   cur_cs;

    mrs_field_check u_check (
        .value  (wr_data[6:0]),
        .is_ext (wr_ext),
        .ok     (value_ok)
    );

    assign wr_ready = !pend[wr_cs];
    assign accept   = wr_en && wr_ready;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_slot
        assign hit[g] = accept && (wr_cs == CS_W'(g));
        mrs_cs_slot #(
            .MR_RESET (MR_RESET)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_hit   (hit[g]),
            .wr_ok    (value_ok),
            .wr_ext   (wr_ext),
            .wr_quiet (wr_quiet),
            .wr_data  (wr_data),
            .retire   (retire[g]),
            .pend     (pend[g]),
            .req      (req_arr[g]),
            .mr_q     (mr_arr[g]),
            .ext_q    (ext_arr[g])
        );
    end

    mrs_cmd_fsm #(
        .NUM_CS (NUM_CS)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (pend),
        .cmd_ack   (cmd_ack),
        .cmd_valid (cmd_valid),
        .cur_cs    (cur_cs),
        .retire    (retire)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_err <= 1'b0;
        end else begin
            wr_err <= accept && !value_ok;
        end
    end

    assign rd_data  = rd_ext ? ext_arr[rd_cs] : mr_arr[rd_cs];
    assign cmd_cs   = cur_cs;
    assign cmd_ba   = req_arr[cur_cs].ba;
    assign cmd_addr = req_arr[cur_cs].addr;
endmodule

// File: rtl/mrs_issuer_chk.sv
module mrs_issuer_chk #(
    parameter int CS_W  = 1,
    parameter int REG_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [CS_W-1:0]  wr_cs,
    input logic             wr_ready,
    input logic             wr_err,
    input logic             cmd_valid,
    input logic             cmd_ack,
    input logic [CS_W-1:0]  cmd_cs,
    input logic [1:0]       cmd_ba,
    input logic [REG_W-1:0] cmd_addr
);
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ack |=> cmd_valid && $stable(cmd_cs) && $stable(cmd_ba) && $stable(cmd_addr)); // R7

    AST_RETIRE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ack |=> !cmd_valid); // R9

    AST_BA_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_ba == 2'b00 || cmd_ba == 2'b10)); // R4

    AST_MODE_PAYLOAD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ba == 2'b00 |-> cmd_addr[3] == 1'b0 && cmd_addr[6:4] >= 3'd1 && cmd_addr[6:4] <= 3'd5); // R2

    AST_STALL_SAME_CS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (cmd_cs == wr_cs) |-> !wr_ready); // R8

    AST_ERR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> $past(wr_en && wr_ready)); // R2
endmodule

bind mrs_issuer mrs_issuer_chk #(.CS_W(CS_W), .REG_W(mrs_pkg::REG_W)) u_chk (.*);

// File: tb/tb_mrs_issuer.sv
module tb_mrs_issuer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [0:0]  wr_cs = '0;
    logic        wr_ext = 1'b0;
    logic        wr_quiet = 1'b0;
    logic [11:0] wr_data = '0;
    logic        wr_ready;
    logic        wr_err;
    logic [0:0]  rd_cs = '0;
    logic        rd_ext = 1'b0;
    logic [11:0] rd_data;
    logic        cmd_valid;
    logic        cmd_ack = 1'b0;
    logic [0:0]  cmd_cs;
    logic [1:0]  cmd_ba;
    logic [11:0] cmd_addr;

    int checks = 0;
    int failures = 0;
    bit armed = 1'b0;
    bit done_flag = 1'b0;

    // reference model state
    bit          m_pend [2];
    logic [1:0]  m_ba   [2];
    logic [11:0] m_addr [2];
    logic [11:0] m_mr   [2];
    logic [11:0] m_ext  [2];
    bit          m_busy;
    int          m_cur;
    bit          m_err;
    bit          t_acc, t_ok, t_done;
    int          t_c;

    always #4 clk = ~clk;

    mrs_issuer dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit mode_legal(input logic [11:0] d);
        int bl, cl;
        bl = int'(d[2:0]);
        cl = int'(d[6:4]);
        return (bl == 2 || bl == 4) && (d[3] == 1'b0) && cl >= 1 && cl <= 5;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_pend[i] = 1'b0; m_ba[i] = 2'b00; m_addr[i] = '0;
                m_mr[i] = 12'h032; m_ext[i] = 12'h000;
            end
            m_busy = 1'b0; m_cur = 0; m_err = 1'b0;
        end else begin
            t_c    = int'(wr_cs);
            t_acc  = wr_en && !m_pend[t_c];
            t_ok   = wr_ext || mode_legal(wr_data);
            t_done = m_busy && cmd_ack;
            m_err  = t_acc && !t_ok;
            if (!m_busy) begin
                if (m_pend[0]) begin m_busy = 1'b1; m_cur = 0; end
                else if (m_pend[1]) begin m_busy = 1'b1; m_cur = 1; end
            end else if (t_done) begin
                m_busy = 1'b0;
                m_pend[m_cur] = 1'b0;
            end
            if (t_acc && t_ok) begin
                if (wr_ext) m_ext[t_c] = wr_data; else m_mr[t_c] = wr_data;
                if (!wr_quiet) begin
                    m_pend[t_c] = 1'b1;
                    m_ba[t_c]   = wr_ext ? 2'b10 : 2'b00;
                    m_addr[t_c] = wr_data;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (armed) begin
            chk("R7 cmd_valid", 32'(cmd_valid), 32'(m_busy));
            if (m_busy) begin
                chk("R9 cmd_cs", 32'(cmd_cs), 32'(m_cur));
                chk("R4 cmd_ba", 32'(cmd_ba), 32'(m_ba[m_cur]));
                chk("R4 cmd_addr", 32'(cmd_addr), 32'(m_addr[m_cur]));
            end
            chk("R8 wr_ready", 32'(wr_ready), 32'(!m_pend[int'(wr_cs)]));
            chk("R2 wr_err", 32'(wr_err), 32'(m_err));
            chk("R3 rd_data", 32'(rd_data), 32'(rd_ext ? m_ext[int'(rd_cs)] : m_mr[int'(rd_cs)]));
        end
    end

    task automatic wr(input bit cs, input bit ext, input logic [11:0] d, input bit quiet);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_cs = cs; wr_ext = ext; wr_data = d; wr_quiet = quiet;
        @(negedge clk); #1;
        wr_en = 1'b0; wr_quiet = 1'b0;
    endtask

    task automatic ack_once();
        @(negedge clk); #1; cmd_ack = 1'b1;
        @(negedge clk); #1; cmd_ack = 1'b0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        #1 rst_n = 1'b1;
        armed = 1'b1;
        #1;
        chk("R1 cmd_valid", 32'(cmd_valid), 32'd0);
        chk("R1 wr_ready", 32'(wr_ready), 32'd1);
        chk("R1 mode reg", 32'(rd_data), 32'h032);
        rd_cs = 1'b1; rd_ext = 1'b1; #1;
        chk("R1 ext reg", 32'(rd_data), 32'h000);

        // mode write, CS0, CL2 BL4
        wr(1'b0, 1'b0, 12'h024, 1'b0);
        chk("R10 not yet valid", 32'(cmd_valid), 32'd0);
        @(negedge clk);
        chk("R10 valid", 32'(cmd_valid), 32'd1);
        chk("R4 ba", 32'(cmd_ba), 32'h0);
        chk("R4 addr", 32'(cmd_addr), 32'h024);
        chk("R4 cs", 32'(cmd_cs), 32'd0);
        repeat (3) @(negedge clk);
        ack_once();

        // ext write, CS1
        wr(1'b1, 1'b1, 12'hABC, 1'b0);
        @(negedge clk);
        chk("R5 ba", 32'(cmd_ba), 32'h2);
        chk("R5 addr", 32'(cmd_addr), 32'hABC);
        chk("R5 cs", 32'(cmd_cs), 32'd1);

        // write CS0 in the same cycle as CS1 is acknowledged
        @(negedge clk); #1;
        wr_en = 1'b1; wr_cs = 1'b0; wr_ext = 1'b0; wr_data = 12'h034; cmd_ack = 1'b1;
        @(negedge clk); #1;
        wr_en = 1'b0; cmd_ack = 1'b0;
        chk("R9 gap", 32'(cmd_valid), 32'd0);
        @(negedge clk);
        chk("R9 next valid", 32'(cmd_valid), 32'd1);
        chk("R9 next cs", 32'(cmd_cs), 32'd0);
        chk("R9 next addr", 32'(cmd_addr), 32'h034);

        // write CS0 during its own acknowledge: stalled
        @(negedge clk); #1;
        wr_en = 1'b1; wr_cs = 1'b0; wr_ext = 1'b0; wr_data = 12'h054; cmd_ack = 1'b1;
        @(negedge clk); #1;
        wr_en = 1'b0; cmd_ack = 1'b0;
        rd_cs = 1'b0; rd_ext = 1'b0; #1;
        chk("R8 stalled during ack", 32'(rd_data), 32'h034);

        // stall behind pending CS1 request
        wr(1'b1, 1'b0, 12'h052, 1'b0);
        wr(1'b1, 1'b0, 12'h044, 1'b0);
        ack_once();
        rd_cs = 1'b1; rd_ext = 1'b0; #1;
        chk("R8 stalled write ignored", 32'(rd_data), 32'h052);
        repeat (2) @(negedge clk);

        // quiet writes
        wr(1'b0, 1'b0, 12'h052, 1'b1);
        repeat (3) @(negedge clk);
        chk("R6 no command", 32'(cmd_valid), 32'd0);
        rd_cs = 1'b0; rd_ext = 1'b0; #1;
        chk("R6 stored", 32'(rd_data), 32'h052);
        wr(1'b1, 1'b1, 12'h3FF, 1'b1);
        repeat (3) @(negedge clk);
        chk("R6 ext no command", 32'(cmd_valid), 32'd0);
        rd_cs = 1'b1; rd_ext = 1'b1; #1;
        chk("R6 ext stored", 32'(rd_data), 32'h3FF);

        // illegal mode values
        rd_cs = 1'b0; rd_ext = 1'b0;
        foreach (bad_vals[i]) begin
            wr(1'b0, 1'b0, bad_vals[i], 1'b0);
            chk("R2 err flag", 32'(wr_err), 32'd1);
            @(negedge clk);
            chk("R2 err drops", 32'(wr_err), 32'd0);
            chk("R2 no command", 32'(cmd_valid), 32'd0);
            chk("R2 reg kept", 32'(rd_data), 32'h052);
        end

        // legal extremes with upper bits set
        wr(1'b1, 1'b0, 12'hF54, 1'b0);
        repeat (2) @(negedge clk);
        ack_once();
        wr(1'b0, 1'b0, 12'h812, 1'b0);
        repeat (2) @(negedge clk);
        ack_once();
        repeat (3) @(negedge clk);
        finish_run();
    end

    logic [11:0] bad_vals [6] = '{12'h02A, 12'h023, 12'h062, 12'h002, 12'h021, 12'h027};
endmodule